// File: doc/BRIEF.md
# Aligned Collection Stream Encoder

The block serializes one fixed record into a big-endian stream of 32-bit words. The record has three parts, in this order: a 32-bit scalar, a counted list of small elements, and an optional 32-bit value. The list elements live in a local store. Software fills the store through a simple write port and can read it back, but only while no encoding is under way. A one-cycle start pulse captures the scalar, the list length, the optional value and its presence flag. The encoder then emits bytes one at a time into a word latch at the current byte offset. It inserts zero bytes wherever a member needs coarser alignment than the current offset gives.

Each list element is fetched in two steps. The encoder first issues a read request to the store at the element index. It then waits for the read data to be valid, emits the element bytes, and acknowledges the read for one cycle. The optional value is held with its presence flag as an extra top bit. A 4-byte header always precedes it: a fixed 16-bit member identifier, then a 16-bit byte count that is 4 when the value is present and 0 when it is absent. The value bytes follow only when it is present. The final word carries a last marker. Two pulses mark the end of a record: one when the last byte enters the latch, and one after the consumer accepts the final word.

Top module: `cdr_stream_encoder`

## Requirements
- R1: After reset, out_valid, out_last, encode_done and finalize_payload are all 0.
- R2: While the encoder is idle, mem_wen writes mem_data_w at mem_addr, and mem_ren loads the entry at mem_addr onto mem_data_r at the next clock edge.
- R3: mem_wen and mem_ren have no effect while an encoding is in progress; the stored entries and mem_data_r keep their values.
- R4: Stream word 0 is the captured scalar and word 1 is the captured 32-bit list length, each with the most significant byte first (bits 31:24 hold the first byte of a word).
- R5: After the length, the list elements at store addresses 0 to length-1 follow in address order, each ELEM_BYTES bytes long with its most significant byte first.
- R6: After the last element, zero bytes are inserted until the byte count is a multiple of 4.
- R7: The next word is the header: OPT_ID in bits 31:16, and in bits 15:0 the value 4 if the optional value was flagged present at start, else 0.
- R8: The optional value follows the header as one word, only when it was flagged present.
- R9: Words are transferred only when out_valid and out_ready are both 1. A stalled word, with its last flag, holds steady. out_last is 1 on the final word only, so a record is 3 + ceil(length*ELEM_BYTES/4) + present words long.
- R10: finalize_payload pulses once per record, and encode_done pulses in the cycle after the final word is accepted.
- R11: A start pulse while an encoding is in progress is ignored.
- R12: A zero list length emits no element bytes and no padding: the header is word 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin encoding; captures the record inputs |
| prim_value | input | 32 | Scalar member |
| seq_len | input | 32 | Number of list elements to encode |
| opt_value | input | 32 | Optional member value |
| opt_present | input | 1 | Optional member present flag |
| mem_addr | input | AW | Store address for software access |
| mem_wen | input | 1 | Store write enable (idle only) |
| mem_ren | input | 1 | Store read enable (idle only) |
| mem_data_w | input | ELEM_W | Store write data |
| mem_data_r | output | ELEM_W | Store read-back data |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 32 | Output word, first byte in bits 31:24 |
| out_last | output | 1 | Final word of the record |
| encode_done | output | 1 | Pulse after the final word is accepted |
| finalize_payload | output | 1 | Pulse when the final byte enters the latch |

## Verification
The checks assume that seq_len never exceeds DEPTH. With a larger length the element index wraps around the store, and the word count is no longer tied to distinct entries. The bench keeps every length between 0 and DEPTH. It never changes the store or starts a record from outside except to test R3 and R11. The assertions also take for granted that the consumer drops out_ready in any cycle of its choosing. The bench throttles out_ready with a pattern that shifts from record to record, so stalls land on element words, padding, the header and the final word.

// File: rtl/cdr_enc_pkg.sv
package cdr_enc_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 32;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRIM,
        ST_LEN,
        ST_EL_REQ,
        ST_EL_WAIT,
        ST_EL_ACK,
        ST_PAD,
        ST_OPT_FETCH,
        ST_OPT_HDR,
        ST_OPT_VAL,
        ST_DRAIN
    } enc_stage_e;

    typedef struct packed {
        logic       vld;
        logic [7:0] data;
        logic       last;
    } byte_beat_t;

    // byte idx of a left-justified 32-bit value, most significant first
    function automatic logic [7:0] be_byte32(input logic [31:0] v, input logic [1:0] idx);
        logic [31:0] s;
        s = v << (8 * int'(idx));
        return s[31:24];
    endfunction

    // place a byte at lane off of a big-endian word
    function automatic logic [31:0] be_place(input logic [7:0] b, input logic [1:0] off);
        return {b, 24'b0} >> (8 * int'(off));
    endfunction

endpackage

// File: rtl/cdr_enc_elem_store.sv
module cdr_enc_elem_store #(
    parameter int DEPTH  = 16,
    parameter int ELEM_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_busy,
    input  logic [AW-1:0]     usr_addr,
    input  logic              usr_wen,
    input  logic              usr_ren,
    input  logic [ELEM_W-1:0] usr_wdata,
    output logic [ELEM_W-1:0] usr_rdata,
    input  logic              enc_req,
    input  logic [AW-1:0]     enc_addr,
    input  logic              enc_ack,
    output logic              enc_rvalid,
    output logic [ELEM_W-1:0] enc_rdata
);

    logic [ELEM_W-1:0] mem [DEPTH];
    logic usr_en;

    assign usr_en = !enc_busy && (usr_wen || usr_ren);

    always_ff @(posedge clk) begin
        if (usr_en && usr_wen) begin
            mem[usr_addr] <= usr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            usr_rdata  <= '0;
            enc_rvalid <= 1'b0;
            enc_rdata  <= '0;
        end else begin
            if (usr_en && usr_ren) begin
                usr_rdata <= mem[usr_addr];
            end
            if (enc_req) begin
                enc_rdata  <= mem[enc_addr];
                enc_rvalid <= 1'b1;
            end else if (enc_ack) begin
                enc_rvalid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cdr_enc_word_packer.sv
module cdr_enc_word_packer
    import cdr_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  byte_beat_t        in_beat,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);

    logic [WORD_W-1:0] word_q;
    logic [1:0]        off_q;
    logic [WORD_W-1:0] merged;
    logic              take;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_beat.vld && in_ready;
    assign merged   = word_q | be_place(in_beat.data, off_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q    <= '0;
            off_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
                out_last  <= 1'b0;
            end
            if (take) begin
                if (off_q == 2'd3 || in_beat.last) begin
                    out_data  <= merged;
                    out_valid <= 1'b1;
                    out_last  <= in_beat.last;
                    word_q    <= '0;
                    off_q     <= '0;
                end else begin
                    word_q <= merged;
                    off_q  <= off_q + 2'd1;
                end
            end
        end
    end

endmodule

// File: rtl/cdr_stream_encoder.sv
module cdr_stream_encoder
    import cdr_enc_pkg::*;
#(
    parameter int          DEPTH      = 16,
    parameter int          ELEM_BYTES = 2,
    parameter logic [15:0] OPT_ID     = 16'h0007,
    localparam int         AW         = $clog2(DEPTH),
    localparam int         ELEM_W     = 8 * ELEM_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       prim_value,
    input  logic [LEN_W-1:0]  seq_len,
    input  logic [31:0]       opt_value,
    input  logic              opt_present,
    input  logic [AW-1:0]     mem_addr,
    input  logic              mem_wen,
    input  logic              mem_ren,
    input  logic [ELEM_W-1:0] mem_data_w,
    output logic [ELEM_W-1:0] mem_data_r,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last,
    output logic              encode_done,
    output logic              finalize_payload
);

    enc_stage_e        stage_q;
    logic [1:0]        sub_q;
    logic [1:0]        align_q;
    logic [31:0]       prim_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  idx_q;
    logic [32:0]       opt_store_q;
    logic [32:0]       opt_q;

    logic              mem_req;
    logic              mem_ack;
    logic              mem_rvalid;
    logic [ELEM_W-1:0] mem_rdata;
    logic [31:0]       elem_left;
    logic [31:0]       hdr_word;
    byte_beat_t        beat;
    logic              pk_ready;
    logic              acc;
    logic              last_xfer;

    assign elem_left = 32'(mem_rdata) << (32 - ELEM_W);
    assign hdr_word  = {OPT_ID, opt_q[32] ? 16'd4 : 16'd0};
    assign last_xfer = out_valid && out_ready && out_last;

    cdr_enc_elem_store #(
        .DEPTH  (DEPTH),
        .ELEM_W (ELEM_W)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .enc_busy   (stage_q != ST_IDLE),
        .usr_addr   (mem_addr),
        .usr_wen    (mem_wen),
        .usr_ren    (mem_ren),
        .usr_wdata  (mem_data_w),
        .usr_rdata  (mem_data_r),
        .enc_req    (mem_req),
        .enc_addr   (idx_q[AW-1:0]),
        .enc_ack    (mem_ack),
        .enc_rvalid (mem_rvalid),
        .enc_rdata  (mem_rdata)
    );

    cdr_enc_word_packer u_packer (
        .clk       (clk),
        .rst       (rst),
        .in_beat   (beat),
        .in_ready  (pk_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    always_comb begin
        beat    = '0;
        mem_req = 1'b0;
        mem_ack = 1'b0;
        case (stage_q)
            ST_PRIM: begin
                beat.vld  = 1'b1;
                beat.data = be_byte32(prim_q, sub_q);
            end
            ST_LEN: begin
                beat.vld  = 1'b1;
                beat.data = be_byte32(len_q, sub_q);
            end
            ST_EL_REQ: mem_req = 1'b1;
            ST_EL_WAIT: begin
                beat.vld  = mem_rvalid;
                beat.data = be_byte32(elem_left, sub_q);
            end
            ST_EL_ACK: mem_ack = 1'b1;
            ST_PAD: beat.vld = (align_q != 2'd0);
            ST_OPT_HDR: begin
                beat.vld  = 1'b1;
                beat.data = be_byte32(hdr_word, sub_q);
                beat.last = !opt_q[32] && (sub_q == 2'd3);
            end
            ST_OPT_VAL: begin
                beat.vld  = 1'b1;
                beat.data = be_byte32(opt_q[31:0], sub_q);
                beat.last = (sub_q == 2'd3);
            end
            default: beat = '0;
        endcase
    end

    assign acc = beat.vld && pk_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q          <= ST_IDLE;
            sub_q            <= '0;
            align_q          <= '0;
            prim_q           <= '0;
            len_q            <= '0;
            idx_q            <= '0;
            opt_store_q      <= '0;
            opt_q            <= '0;
            encode_done      <= 1'b0;
            finalize_payload <= 1'b0;
        end else begin
            finalize_payload <= acc && beat.last;
            encode_done      <= last_xfer;
            if (acc) begin
                align_q <= align_q + 2'd1;
            end
            case (stage_q)
                ST_IDLE: begin
                    if (start) begin
                        prim_q      <= prim_value;
                        len_q       <= seq_len;
                        opt_store_q <= {opt_present, opt_value};
                        sub_q       <= '0;
                        align_q     <= '0;
                        stage_q     <= ST_PRIM;
                    end
                end
                ST_PRIM: begin
                    if (acc) begin
                        sub_q <= sub_q + 2'd1;
                        if (sub_q == 2'd3) begin
                            sub_q   <= '0;
                            stage_q <= ST_LEN;
                        end
                    end
                end
                ST_LEN: begin
                    if (acc) begin
                        sub_q <= sub_q + 2'd1;
                        if (sub_q == 2'd3) begin
                            sub_q   <= '0;
                            idx_q   <= '0;
                            stage_q <= (len_q == '0) ? ST_PAD : ST_EL_REQ;
                        end
                    end
                end
                ST_EL_REQ: begin
                    sub_q   <= '0;
                    stage_q <= ST_EL_WAIT;
                end
                ST_EL_WAIT: begin
                    if (acc) begin
                        sub_q <= sub_q + 2'd1;
                        if (sub_q == 2'(ELEM_BYTES - 1)) begin
                            sub_q   <= '0;
                            stage_q <= ST_EL_ACK;
                        end
                    end
                end
                ST_EL_ACK: begin
                    idx_q   <= idx_q + 1'b1;
                    stage_q <= (idx_q == len_q - 1'b1) ? ST_PAD : ST_EL_REQ;
                end
                ST_PAD: begin
                    if (align_q == 2'd0) begin
                        stage_q <= ST_OPT_FETCH;
                    end
                end
                ST_OPT_FETCH: begin
                    opt_q   <= opt_store_q;
                    sub_q   <= '0;
                    stage_q <= ST_OPT_HDR;
                end
                ST_OPT_HDR: begin
                    if (acc) begin
                        sub_q <= sub_q + 2'd1;
                        if (sub_q == 2'd3) begin
                            sub_q   <= '0;
                            stage_q <= opt_q[32] ? ST_OPT_VAL : ST_DRAIN;
                        end
                    end
                end
                ST_OPT_VAL: begin
                    if (acc) begin
                        sub_q <= sub_q + 2'd1;
                        if (sub_q == 2'd3) begin
                            sub_q   <= '0;
                            stage_q <= ST_DRAIN;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (last_xfer) begin
                        stage_q <= ST_IDLE;
                    end
                end
                default: stage_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cdr_enc_checker.sv
module cdr_enc_checker (
    input logic        clk,
    input logic        rst,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_last,
    input logic        encode_done,
    input logic        finalize_payload,
    input logic        rd_valid,
    input logic        rd_ack
);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R9

    AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last |=> encode_done); // R10

    AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (rst)
        $rose(encode_done) |-> $past(out_valid && out_ready && out_last)); // R10

    AST_FINAL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        finalize_payload |=> !finalize_payload); // R10

    AST_ACK_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        rd_ack |-> rd_valid); // R5

    AST_LAST_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid); // R9

endmodule

bind cdr_stream_encoder cdr_enc_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .out_valid        (out_valid),
    .out_ready        (out_ready),
    .out_data         (out_data),
    .out_last         (out_last),
    .encode_done      (encode_done),
    .finalize_payload (finalize_payload),
    .rd_valid         (mem_rvalid),
    .rd_ack           (mem_ack)
);

// File: tb/cdr_stream_encoder_bench.sv
`timescale 1ns/1ps
module cdr_stream_encoder_bench;

    localparam int          DEPTH  = 16;
    localparam int          AW     = $clog2(DEPTH);
    localparam int          ELEM_W = 16;
    localparam logic [15:0] OPT_ID = 16'h0007;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [31:0]       prim_value = '0;
    logic [31:0]       seq_len = '0;
    logic [31:0]       opt_value = '0;
    logic              opt_present = 1'b0;
    logic [AW-1:0]     mem_addr = '0;
    logic              mem_wen = 1'b0;
    logic              mem_ren = 1'b0;
    logic [ELEM_W-1:0] mem_data_w = '0;
    logic [ELEM_W-1:0] mem_data_r;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [31:0]       out_data;
    logic              out_last;
    logic              encode_done;
    logic              finalize_payload;

    int checks = 0;
    int fails  = 0;
    int fin_cnt = 0;
    int cyc = 0;

    logic [ELEM_W-1:0] mdl [DEPTH];
    logic [7:0]        exp_b [64];
    int                nb;

    always #2 clk = ~clk;

    cdr_stream_encoder #(.DEPTH(DEPTH), .ELEM_BYTES(2), .OPT_ID(OPT_ID)) u_cdr_stream_encoder (
        .clk(clk), .rst(rst), .start(start), .prim_value(prim_value), .seq_len(seq_len),
        .opt_value(opt_value), .opt_present(opt_present), .mem_addr(mem_addr),
        .mem_wen(mem_wen), .mem_ren(mem_ren), .mem_data_w(mem_data_w), .mem_data_r(mem_data_r),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .encode_done(encode_done), .finalize_payload(finalize_payload)
    );

    always @(negedge clk) begin
        cyc++;
        if (finalize_payload) fin_cnt++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_b(input logic [7:0] b);
        exp_b[nb] = b;
        nb++;
    endtask

    task automatic user_write(input int a, input logic [ELEM_W-1:0] d);
        mem_addr   = AW'(a);
        mem_data_w = d;
        mem_wen    = 1'b1;
        @(negedge clk);
        mem_wen = 1'b0;
        mdl[a]  = d;
    endtask

    task automatic user_readback(input int a, input string tag);
        mem_addr = AW'(a);
        mem_ren  = 1'b1;
        @(negedge clk);
        mem_ren = 1'b0;
        chk(mem_data_r == mdl[a], tag, 32'(mem_data_r), 32'(mdl[a]));
    endtask

    task automatic run_record(input int len, input bit pres, input int run);
        int nw, k, fin0, pad_word, hdr_word, waited;
        bit got_last;
        logic [31:0] ew;
        string tag;
        for (int i = 0; i < len; i++) begin
            user_write(i, ELEM_W'(i * 16'h1357 + run * 16'h0101 + 16'h00A5));
        end
        user_readback(0, "R2");
        prim_value  = 32'hC0DE_0000 + 32'(run);
        seq_len     = 32'(len);
        opt_value   = 32'h5A00_0000 | 32'(run * 17);
        opt_present = pres;
        nb = 0;
        for (int i = 3; i >= 0; i--) push_b(prim_value[8*i +: 8]);
        for (int i = 3; i >= 0; i--) push_b(seq_len[8*i +: 8]);
        for (int i = 0; i < len; i++) begin
            push_b(mdl[i][15:8]);
            push_b(mdl[i][7:0]);
        end
        pad_word = (nb % 4 != 0) ? nb / 4 : -1;
        while (nb % 4 != 0) push_b(8'h00);
        hdr_word = nb / 4;
        push_b(OPT_ID[15:8]);
        push_b(OPT_ID[7:0]);
        push_b(8'h00);
        push_b(pres ? 8'h04 : 8'h00);
        if (pres) for (int i = 3; i >= 0; i--) push_b(opt_value[8*i +: 8]);
        nw   = nb / 4;
        fin0 = fin_cnt;
        start = 1'b1;
        @(negedge clk);
        // R11 and R3: second start and stray store accesses during encoding
        mem_addr   = '0;
        mem_data_w = 16'hDEAD;
        mem_wen    = 1'b1;
        mem_ren    = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        mem_wen = 1'b0;
        mem_ren = 1'b0;
        k = 0;
        got_last = 1'b0;
        waited = 0;
        while (!got_last && waited < 2000) begin
            waited++;
            if (out_valid && (((cyc * 3 + run) % 4) != 0)) begin
                ew = {exp_b[4*k], exp_b[4*k+1], exp_b[4*k+2], exp_b[4*k+3]};
                if (k < 2) tag = "R4";
                else if (k == pad_word) tag = "R6";
                else if (k < hdr_word) tag = "R5";
                else if (k == hdr_word) tag = "R7";
                else tag = "R8";
                if (k < nw) chk(out_data == ew, tag, out_data, ew);
                else chk(1'b0, "R9", 32'(k), 32'(nw));
                chk(out_last == (k == nw - 1), "R9", 32'(out_last), 32'(k == nw - 1));
                got_last = out_last;
                k++;
                out_ready = 1'b1;
            end else begin
                out_ready = 1'b0;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(encode_done == 1'b1, "R10", 32'(encode_done), 32'd1);
        chk(k == nw, "R9", 32'(k), 32'(nw));
        if (len == 0) chk(hdr_word == 2 && k == 3 + int'(pres), "R12", 32'(k), 32'(3 + int'(pres)));
        @(negedge clk);
        chk(encode_done == 1'b0, "R10", 32'(encode_done), 32'd0);
        chk(fin_cnt == fin0 + 1, "R10", 32'(fin_cnt - fin0), 32'd1);
        chk(out_valid == 1'b0, "R11", 32'(out_valid), 32'd0);
        user_readback(0, "R3");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(out_valid == 1'b0, "R1", 32'(out_valid), 32'd0);
        chk(out_last == 1'b0, "R1", 32'(out_last), 32'd0);
        chk(encode_done == 1'b0, "R1", 32'(encode_done), 32'd0);
        chk(finalize_payload == 1'b0, "R1", 32'(finalize_payload), 32'd0);
        for (int i = 0; i < DEPTH; i++) user_write(i, '0);
        begin
            int run;
            run = 0;
            for (int len = 0; len <= 7; len++) begin
                for (int p = 0; p < 2; p++) begin
                    run_record(len, p[0], run);
                    run++;
                end
            end
            run_record(DEPTH, 1'b1, run);
            run_record(DEPTH - 1, 1'b0, run + 1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule